// File: doc/BRIEF.md
# Page-Mode Read Controller

This block turns single read requests from an internal port into read cycles on an external asynchronous memory that supports fast in-page bursts. It drives the memory address, an active-low chip select and an active-low read strobe. It captures the returned data on the last strobe cycle and hands it back to the requester with a one-cycle valid pulse.

The block remembers the page of the last read. The page size is chosen at run time as 4, 8, 16 or 32 bytes, and each page is aligned to its own size. A read that lands in the remembered page while chip select is still held gets the short in-page strobe count. Every other read gets the longer first-access count. The page memory is dropped when page mode is switched off, when a write is signalled, when chip select is released, and at the next read after any change to the page size or to either timing value.

The sequencer has three named states. IDLE has chip select released and the controller ready for a request. STROBE has chip select and the read strobe asserted while the strobe counter runs down. HOLD is the single cycle after a read: chip select is still held, the data-valid pulse is out, and a new request may be taken. The transitions are: IDLE to STROBE on an accepted request; STROBE to STROBE while the counter is non-zero; STROBE to HOLD when the counter reaches zero; HOLD to STROBE on an accepted request (back-to-back, chip select kept); HOLD to IDLE when no request is pending (chip select released).

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, mem_cs_n and mem_rd_n are 1, rsp_valid is 0 and req_ready is 1.
- R2: A read that is not a page hit holds mem_rd_n low for cfg_t_first+1 clock cycles.
- R3: A page hit holds mem_rd_n low for cfg_t_page+1 clock cycles. A read is a page hit when it is accepted in HOLD, page mode is on, the stored page is valid, the configuration is unchanged and the page matches.
- R4: Page match compares address bits above the in-page offset. cfg_pg_sel values 0, 1, 2 and 3 select 4, 8, 16 and 32 byte pages, whose in-page offset is address bits [1+cfg_pg_sel:0].
- R5: While cfg_pg_en is 0, every read uses the first-access timing.
- R6: The stored page is invalidated when chip select is released (HOLD to IDLE), when wr_notify is 1 (including in the accepting cycle), and while cfg_pg_en is 0.
- R7: If cfg_pg_sel, cfg_t_first or cfg_t_page differ from their values at the previous accepted read, the next read is a first access.
- R8: Read data is mem_din sampled on the last strobe cycle. It is presented on rsp_data with rsp_valid high for exactly one cycle, the cycle after mem_rd_n rises.
- R9: req_ready is 0 while the strobe is asserted and 1 otherwise. Chip select stays low between back-to-back reads, and mem_rd_n low implies mem_cs_n low.
- R10: When cfg_wide is 1 at acceptance, mem_addr bit 0 is driven 0.
- R11: mem_addr stays stable for the whole strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pg_en | input | 1 | Page-mode enable |
| cfg_pg_sel | input | 2 | Page size: 0=4, 1=8, 2=16, 3=32 bytes |
| cfg_t_first | input | TIM_W | First-access strobe count (cycles minus one) |
| cfg_t_page | input | TIM_W | In-page strobe count (cycles minus one) |
| cfg_wide | input | 1 | Device is 16 bits wide; address bit 0 is forced low |
| wr_notify | input | 1 | A write happened; drop the stored page |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_ready | output | 1 | Request is accepted when this and req_valid are both high |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_din | input | DATA_W | Memory read data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_data | output | DATA_W | Captured read data |

## Verification
The bench builds the block with its defaults: a 24-bit address, a 16-bit data path and 4-bit timing counts. Counts up to 15 fit, which keeps each strobe short, so many reads fit in a run and both count extremes (0 and larger values) come into reach. All four page sizes are driven with addresses that step just inside and just across each page boundary. Random back-to-back chains mix in gaps, page-mode toggles and configuration changes taken in HOLD, so every path that drops the stored page is hit against a bench model of the page memory.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2
    } pgrd_state_t;

    // Offset mask of a page: 4 << sel bytes
    function automatic logic [5:0] page_offset_mask(input logic [1:0] sel);
        page_offset_mask = (6'd4 << sel) - 6'd1;
    endfunction
endpackage

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
    parameter int ADDR_W = 24,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pg_en,
    input  logic [1:0]        cfg_pg_sel,
    input  logic [TIM_W-1:0]  cfg_t_first,
    input  logic [TIM_W-1:0]  cfg_t_page,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic              in_hold,
    input  logic              capture,
    input  logic              drop,
    output logic              hit
);
    import pgrd_pkg::*;

    localparam int SNAP_W = 2 + 2 * TIM_W;

    logic [ADDR_W-1:0] page_q;
    logic [SNAP_W-1:0] snap_q;
    logic              vld_q;
    logic [SNAP_W-1:0] snap_now;
    logic [ADDR_W-1:0] keep_mask;

    assign snap_now  = {cfg_pg_sel, cfg_t_first, cfg_t_page};
    assign keep_mask = ~{{(ADDR_W-6){1'b0}}, page_offset_mask(cfg_pg_sel)};

    always_comb begin
        hit = vld_q && in_hold && cfg_pg_en && !drop
              && (snap_q == snap_now)
              && (((look_addr ^ page_q) & keep_mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            page_q <= '0;
            snap_q <= '0;
        end else begin
            if (capture) begin
                page_q <= look_addr;
                snap_q <= snap_now;
            end
            if (drop || !cfg_pg_en)
                vld_q <= 1'b0;
            else if (capture)
                vld_q <= 1'b1;
        end
    end

    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cfg_pg_en); // R5
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !hit); // R6
endmodule

// File: rtl/pgrd_strobe_cnt.sv
module pgrd_strobe_cnt #(
    parameter int TIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TIM_W-1:0] load_val,
    output logic             done
);
    logic [TIM_W-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done); // R2
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pg_en,
    input  logic [1:0]        cfg_pg_sel,
    input  logic [TIM_W-1:0]  cfg_t_first,
    input  logic [TIM_W-1:0]  cfg_t_page,
    input  logic              cfg_wide,
    input  logic              wr_notify,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    import pgrd_pkg::*;

    pgrd_state_t state_q, state_d;
    logic        accept;
    logic        hit;
    logic        done;
    logic        drop;
    logic        finish;

    assign req_ready = (state_q != ST_STROBE);
    assign accept    = req_valid && req_ready;
    assign finish    = (state_q == ST_STROBE) && done;
    assign drop      = wr_notify || ((state_q == ST_HOLD) && !req_valid);

    pgrd_page_track #(.ADDR_W(ADDR_W), .TIM_W(TIM_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pg_en  (cfg_pg_en),
        .cfg_pg_sel (cfg_pg_sel),
        .cfg_t_first(cfg_t_first),
        .cfg_t_page (cfg_t_page),
        .look_addr  (req_addr),
        .in_hold    (state_q == ST_HOLD),
        .capture    (accept),
        .drop       (drop),
        .hit        (hit)
    );

    pgrd_strobe_cnt #(.TIM_W(TIM_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(hit ? cfg_t_page : cfg_t_first),
        .done    (done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_STROBE;
            ST_STROBE: if (done)   state_d = ST_HOLD;
            ST_HOLD:   state_d = accept ? ST_STROBE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_rd_n  <= 1'b1;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= finish;
            if (finish) begin
                rsp_data <= mem_din;
                mem_rd_n <= 1'b1;
            end
            if (accept) begin
                mem_cs_n <= 1'b0;
                mem_rd_n <= 1'b0;
                mem_addr <= {req_addr[ADDR_W-1:1], req_addr[0] & ~cfg_wide};
            end else if (state_q == ST_HOLD) begin
                mem_cs_n <= 1'b1;
            end
        end
    end

    AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_cs_n); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !finish) |=> $stable(mem_addr)); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_WIDE_A0: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_wide) |=> !mem_addr[0]); // R10
    AST_NO_READY_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && !rsp_valid) |-> (state_q == ST_STROBE)); // R9
endmodule

// File: tb/pgrd_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgrd_ctrl_tb_top;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int TIM_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pg_en = 1'b1;
    logic [1:0] cfg_pg_sel = 2'd0;
    logic [TIM_W-1:0] cfg_t_first = 4'd5;
    logic [TIM_W-1:0] cfg_t_page = 4'd1;
    logic cfg_wide = 1'b0;
    logic wr_notify = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_cs_n, mem_rd_n;
    logic [DATA_W-1:0] mem_din;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;

    // model of the page memory
    logic              m_vld = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [9:0]        m_snap = '0;

    always #10 clk = ~clk;

    assign mem_din = mem_addr[15:0] ^ 16'hA5C3;

    pgrd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIM_W(TIM_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pg_en(cfg_pg_en), .cfg_pg_sel(cfg_pg_sel),
        .cfg_t_first(cfg_t_first), .cfg_t_page(cfg_t_page), .cfg_wide(cfg_wide),
        .wr_notify(wr_notify), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_din(mem_din), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_same_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b,
                                             input logic [1:0] sel);
        int sh = 2 + int'(sel);
        return (a >> sh) == (b >> sh);
    endfunction

    // Breaks a chain: no request in HOLD, chip select goes high
    task automatic gap();
        @(negedge clk);
        @(negedge clk);
        m_vld = 1'b0;
    endtask

    // Issues one read; call at a negedge. Returns at the negedge in HOLD.
    task automatic rd(input logic [ADDR_W-1:0] a, input string note);
        logic hit;
        logic [ADDR_W-1:0] exp_a;
        int len, exp_len;
        logic addr_moved, ready_seen;
        string tag;
        req_addr  = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        hit = mem_cs_n == 1'b0 && m_vld && cfg_pg_en && !wr_notify &&
              m_snap == {cfg_pg_sel, cfg_t_first, cfg_t_page} &&
              model_same_page(a, m_addr, cfg_pg_sel);
        exp_len = hit ? int'(cfg_t_page) + 1 : int'(cfg_t_first) + 1;
        exp_a   = {a[ADDR_W-1:1], a[0] & ~cfg_wide};
        m_vld   = cfg_pg_en && !wr_notify;
        m_addr  = a;
        m_snap  = {cfg_pg_sel, cfg_t_first, cfg_t_page};
        @(posedge clk);
        #1 req_valid = 1'b0;
        wr_notify = 1'b0;
        len = 0; addr_moved = 1'b0; ready_seen = 1'b0;
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            if (!mem_rd_n) len++;
            if (mem_addr !== exp_a) addr_moved = 1'b1;
            if (req_ready) ready_seen = 1'b1;
            if (len > 40) break;
        end
        tag = hit ? "R3" : (!cfg_pg_en ? "R5" : "R2");
        check({tag, " strobe length ", note}, len, exp_len);
        check({"R8 data ", note}, rsp_data, exp_a[15:0] ^ 16'hA5C3);
        check({"R11 address stable ", note}, addr_moved, 1'b0);
        check({"R9 ready low in strobe / cs held in HOLD ", note},
              {ready_seen, mem_cs_n, req_ready}, {1'b0, 1'b0, 1'b1});
        if (cfg_wide) check({"R10 A0 low ", note}, mem_addr[0], 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int dummy;
        dummy = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        check("R1 cs_n reset", mem_cs_n, 1'b1);
        check("R1 rd_n reset", mem_rd_n, 1'b1);
        check("R1 rsp_valid reset", rsp_valid, 1'b0);
        check("R1 req_ready reset", req_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 then R3: first access then in-page
        rd(24'h000100, "first");
        rd(24'h000102, "in page");
        // rsp_valid one cycle only (R8)
        rd(24'h000103, "in page 2");
        @(negedge clk);
        check("R8 single pulse", rsp_valid, 1'b0);
        check("R6 cs released after HOLD", mem_cs_n, 1'b1);
        m_vld = 1'b0;
        @(negedge clk);

        // R4: each page size, just inside and just across the boundary
        for (int s = 0; s < 4; s++) begin
            int psz;
            cfg_pg_sel = 2'(s);
            psz = 4 << s;
            rd(24'h002000, "R4 base");
            rd(24'h002000 + 24'(psz - 1), "R4 last in page");
            rd(24'h002000 + 24'(psz), "R4 across boundary");
            gap();
        end

        // R6: write notify in the accepting cycle, then chained read misses too
        cfg_pg_sel = 2'd3;
        rd(24'h004000, "R6 setup");
        wr_notify = 1'b1;
        rd(24'h004004, "R6 write at accept");
        rd(24'h004008, "R6 after write");
        // R6: chip select release clears page
        gap();
        rd(24'h00400C, "R6 after gap");
        // R5: page mode off
        cfg_pg_en = 1'b0;
        rd(24'h004010, "R5 off a");
        rd(24'h004011, "R5 off b");
        cfg_pg_en = 1'b1;
        rd(24'h004012, "R5 re-enabled miss");
        rd(24'h004013, "R5 re-enabled hit");
        // R7: config changes between transactions
        cfg_t_page = 4'd0;
        rd(24'h004014, "R7 t_page changed");
        rd(24'h004015, "R7 t_page 0 hit");
        cfg_t_first = 4'd9;
        rd(24'h004016, "R7 t_first changed");
        cfg_pg_sel = 2'd2;
        rd(24'h004017, "R7 sel changed");
        // R10: wide device
        cfg_wide = 1'b1;
        rd(24'h004019, "R10 odd addr");
        rd(24'h00401B, "R10 odd addr hit");
        cfg_wide = 1'b0;
        gap();

        // random chains
        for (int i = 0; i < 120; i++) begin
            logic [ADDR_W-1:0] a;
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 10) gap();
            if (r >= 10 && r < 15) cfg_pg_sel = 2'($urandom_range(0, 3));
            if (r >= 15 && r < 18) cfg_t_first = 4'($urandom_range(0, 7));
            if (r >= 18 && r < 21) cfg_t_page = 4'($urandom_range(0, 3));
            if (r >= 21 && r < 25) cfg_pg_en = ~cfg_pg_en;
            if (r >= 25 && r < 28) wr_notify = 1'b1;
            if ($urandom_range(0, 3) != 0)
                a = m_addr + 24'($urandom_range(0, 8));
            else
                a = 24'($urandom_range(0, 4095));
            rd(a, "random");
        end
        gap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule